// File: doc/BRIEF.md
# Calibrated Cable Length Estimator

This block turns a per-link quality metric into a cable length estimate while the link is up. Software first loads a six-point calibration table through a simple write port: six length entries, each the length in meters divided by 8 and rounded, and two banks of six 12-bit metric entries. One bank serves the low-amplitude (1.0 Vpp) transmit mode and the other the high-amplitude (2.4 Vpp) mode. The table is volatile and clears on reset.

Once the link has been up for a programmable settling interval, the first valid metric word is sampled. Its upper twelve bits form the metric code. The bank chosen by the amplitude mode at that moment is searched for the two adjacent points that bracket the code. The block then interpolates linearly between their lengths with a sequential divider and publishes a result word with a completion flag. Each link-up yields one estimate. Dropping the link clears the result and starts the settling interval again.

Top module: `cle_len_est`

## Requirements
- R1: Writes decode `wr_addr[4:3]` as the table (0 = length, data bits 7:0; 1 = low-amplitude metric bank, data bits 11:0; 2 = high-amplitude metric bank, data bits 11:0; 3 = no table) and `wr_addr[2:0]` as the point index 0..5. Index 6 or 7, or table 3, changes no entry.
- R2: A `metric_valid` strobe is ignored until `link_up` has been high for `SETTLE_CYC` consecutive clock edges. A strobe at the next edge or any later one is accepted.
- R3: The metric code is `metric_in[15:4]`, and bits 3:0 have no effect on the estimate.
- R4: The bank used is the low-amplitude bank when `amp_hi` is 0 at the sampling edge and the high-amplitude bank when it is 1. Later changes of `amp_hi` do not affect that estimate.
- R5: For the lowest-index segment i with M[i] < M[i+1] and M[i] <= code < M[i+1], the estimate in meters is 8*L[i] + trunc(8*(code-M[i])*(L[i+1]-L[i]) / (M[i+1]-M[i])). Truncation is toward zero, and the length difference may be negative.
- R6: A code at or below M[0] gives 8*L[0]. A code that no usable segment brackets, including one at or above the last point, gives 8*L[5]. A code equal to an interior point metric gives that point's length exactly.
- R7: A segment whose metric does not rise (M[i+1] <= M[i]) is skipped in the search.
- R8: `result` is {done, 4'b0000, meters[10:0]} and reads zero while no estimate is complete. The done flag and length appear exactly 25 clock edges after the sampling edge.
- R9: A low `link_up` at a clock edge clears `result` and any estimate in progress, and the settling interval restarts.
- R10: After an estimate completes, `result` holds and further strobes are ignored until the link drops. Strobes during an estimate in progress are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the table and result |
| wr_en | input | 1 | Calibration table write strobe |
| wr_addr | input | 5 | Table select (4:3) and point index (2:0) |
| wr_data | input | 16 | Write data |
| link_up | input | 1 | Link established indication |
| amp_hi | input | 1 | Transmit amplitude mode, 1 = high amplitude |
| metric_valid | input | 1 | Live metric word strobe |
| metric_in | input | 16 | Live metric word |
| result | output | 16 | Done flag in bit 15, length in meters in bits 10:0 |

## Verification
The bench targets a strobe that arrives before the settling interval has expired. A design that ignores the settling timer would publish an early estimate. It also checks codes equal to the first, an interior and the last point, and codes beyond either end, where an off-by-one comparison would interpolate instead of clamping. A table with a falling metric segment and a segment with falling length expose designs that search blindly or treat the length difference as unsigned. The amplitude mode is flipped right after sampling, the low nibble of the metric is varied, and the link is dropped mid-computation. A design that fails these would use the wrong bank, let noise bits move the result, or resume a stale estimate.

// File: rtl/cle_pkg.sv
package cle_pkg;
    localparam int NPTS    = 6;
    localparam int LEN_W   = 8;
    localparam int MET_W   = 12;
    localparam int WORD_W  = 16;
    localparam int FRAC_W  = 3;
    localparam int MTR_W   = 11;
    localparam int IDX_W   = 3;
    localparam int GRP_W   = 2;
    localparam int ADDR_W  = IDX_W + GRP_W;
    localparam int PROD_W  = MET_W + LEN_W;
    localparam int NUM_W   = PROD_W + FRAC_W;
    localparam int SUM_W   = MTR_W + 1;
    localparam int LATENCY = NUM_W + 2;

    typedef logic [LEN_W-1:0] len_t;
    typedef logic [MET_W-1:0] met_t;

    typedef enum logic [GRP_W-1:0] {
        GRP_LEN  = 2'd0,
        GRP_LO   = 2'd1,
        GRP_HI   = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SRCH = 2'd1,
        ST_DIV  = 2'd2,
        ST_HOLD = 2'd3
    } est_state_e;

    typedef struct packed {
        len_t base;
        len_t span;
        logic neg;
        met_t dm;
        met_t dmax;
    } seg_t;

    function automatic len_t len_diff(len_t a, len_t b);
        return (a >= b) ? len_t'(a - b) : len_t'(b - a);
    endfunction
endpackage

// File: rtl/cle_cal_regs.sv
module cle_cal_regs
    import cle_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [NPTS-1:0][LEN_W-1:0]  lens,
    output logic [NPTS-1:0][MET_W-1:0]  met_lo,
    output logic [NPTS-1:0][MET_W-1:0]  met_hi
);
    grp_e             grp;
    logic [IDX_W-1:0] idx;
    logic             unused_top;

    assign grp        = grp_e'(wr_addr[ADDR_W-1:IDX_W]);
    assign idx        = wr_addr[IDX_W-1:0];
    assign unused_top = ^wr_data[WORD_W-1:MET_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            lens   <= '0;
            met_lo <= '0;
            met_hi <= '0;
        end else if (wr_en) begin
            for (int p = 0; p < NPTS; p++) begin
                if (idx == IDX_W'(p)) begin
                    case (grp)
                        GRP_LEN: lens[p]   <= wr_data[LEN_W-1:0];
                        GRP_LO:  met_lo[p] <= wr_data[MET_W-1:0];
                        GRP_HI:  met_hi[p] <= wr_data[MET_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/cle_settle_timer.sv
module cle_settle_timer #(
    parameter int unsigned SETTLE_CYC = 300000
) (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !link_up)
            cnt <= '0;
        else if (cnt != CW'(SETTLE_CYC))
            cnt <= cnt + CW'(1);
    end

    assign settled = (cnt == CW'(SETTLE_CYC));
endmodule

// File: rtl/cle_seg_search.sv
module cle_seg_search
    import cle_pkg::*;
(
    input  met_t                        code,
    input  logic [NPTS-1:0][LEN_W-1:0]  lens,
    input  logic [NPTS-1:0][MET_W-1:0]  mets,
    output seg_t                        seg
);
    logic [NPTS-2:0] hit;

    for (genvar g = 0; g < NPTS - 1; g++) begin : g_seg
        assign hit[g] = (mets[g+1] > mets[g]) &&
                        (code >= mets[g]) && (code < mets[g+1]);
    end

    always_comb begin
        seg.base = lens[NPTS-1];
        seg.span = '0;
        seg.neg  = 1'b0;
        seg.dm   = '0;
        seg.dmax = met_t'(1);
        if (code <= mets[0]) begin
            seg.base = lens[0];
        end else begin
            for (int i = NPTS - 2; i >= 0; i--) begin
                if (hit[i]) begin
                    seg.base = lens[i];
                    seg.span = len_diff(lens[i+1], lens[i]);
                    seg.neg  = (lens[i+1] < lens[i]);
                    seg.dm   = code - mets[i];
                    seg.dmax = mets[i+1] - mets[i];
                end
            end
        end
    end
endmodule

// File: rtl/cle_divider.sv
module cle_divider #(
    parameter int NW = 23,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [NW-1:0] quo,
    output logic          fin
);
    localparam int CNT_W = $clog2(NW);

    logic [DW:0]      rem;
    logic [DW-1:0]    den_r;
    logic [CNT_W-1:0] step;
    logic             run;
    logic [DW:0]      trial;
    logic             take;

    assign trial = {rem[DW-1:0], quo[NW-1]};
    assign take  = (trial >= {1'b0, den_r});

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            rem   <= '0;
            den_r <= '0;
            quo   <= '0;
            step  <= '0;
            run   <= 1'b0;
            fin   <= 1'b0;
        end else if (start) begin
            rem   <= '0;
            den_r <= den;
            quo   <= num;
            step  <= '0;
            run   <= 1'b1;
            fin   <= 1'b0;
        end else if (run) begin
            rem  <= take ? (trial - {1'b0, den_r}) : trial;
            quo  <= {quo[NW-2:0], take};
            step <= step + CNT_W'(1);
            if (step == CNT_W'(NW - 1)) begin
                run <= 1'b0;
                fin <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end
endmodule

// File: rtl/cle_len_est.sv
module cle_len_est
    import cle_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 300000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              link_up,
    input  logic              amp_hi,
    input  logic              metric_valid,
    input  logic [WORD_W-1:0] metric_in,
    output logic [WORD_W-1:0] result
);
    logic [NPTS-1:0][LEN_W-1:0] lens;
    logic [NPTS-1:0][MET_W-1:0] met_lo;
    logic [NPTS-1:0][MET_W-1:0] met_hi;
    logic [NPTS-1:0][MET_W-1:0] met_sel;

    est_state_e        state;
    met_t              code_r;
    logic              hi_r;
    len_t              base_r;
    len_t              span_r;
    logic              neg_r;
    logic              done_r;
    logic [MTR_W-1:0]  meters_r;

    logic              settled;
    seg_t              seg_w;
    logic [PROD_W-1:0] prod;
    logic [NUM_W-1:0]  div_num;
    logic [NUM_W-1:0]  div_quo;
    logic              div_fin;
    logic              in_srch;
    logic [SUM_W-1:0]  base8;
    logic [SUM_W-1:0]  quo_s;
    logic [SUM_W-1:0]  mtr_sum;
    logic              unused_bits;

    cle_cal_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lens    (lens),
        .met_lo  (met_lo),
        .met_hi  (met_hi)
    );

    cle_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .link_up (link_up),
        .settled (settled)
    );

    assign met_sel = hi_r ? met_hi : met_lo;

    cle_seg_search u_search (
        .code (code_r),
        .lens (lens),
        .mets (met_sel),
        .seg  (seg_w)
    );

    assign in_srch = (state == ST_SRCH);
    assign prod    = {{LEN_W{1'b0}}, seg_w.dm} * {{MET_W{1'b0}}, seg_w.span};
    assign div_num = {prod, {FRAC_W{1'b0}}};

    cle_divider #(.NW(NUM_W), .DW(MET_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .abort (!link_up),
        .start (in_srch),
        .num   (div_num),
        .den   (seg_w.dmax),
        .quo   (div_quo),
        .fin   (div_fin)
    );

    assign base8       = {1'b0, base_r, {FRAC_W{1'b0}}};
    assign quo_s       = div_quo[SUM_W-1:0];
    assign mtr_sum     = neg_r ? (base8 - quo_s) : (base8 + quo_s);
    assign unused_bits = ^{div_quo[NUM_W-1:SUM_W], mtr_sum[SUM_W-1], metric_in[WORD_W-MET_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst || !link_up) begin
            state    <= ST_IDLE;
            code_r   <= '0;
            hi_r     <= 1'b0;
            base_r   <= '0;
            span_r   <= '0;
            neg_r    <= 1'b0;
            done_r   <= 1'b0;
            meters_r <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (settled && metric_valid) begin
                        code_r <= metric_in[WORD_W-1:WORD_W-MET_W];
                        hi_r   <= amp_hi;
                        state  <= ST_SRCH;
                    end
                end
                ST_SRCH: begin
                    base_r <= seg_w.base;
                    span_r <= seg_w.span;
                    neg_r  <= seg_w.neg;
                    state  <= ST_DIV;
                end
                ST_DIV: begin
                    if (div_fin) begin
                        meters_r <= mtr_sum[MTR_W-1:0];
                        done_r   <= 1'b1;
                        state    <= ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    assign result = {done_r, {(WORD_W-MTR_W-1){1'b0}}, meters_r};
endmodule

// File: rtl/cle_len_est_chk.sv
module cle_len_est_chk
    import cle_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 300000
) (
    input logic              clk,
    input logic              rst,
    input logic              link_up,
    input logic [WORD_W-1:0] result,
    input logic              in_srch,
    input seg_t              seg_w,
    input logic              div_fin,
    input logic [NUM_W-1:0]  div_quo,
    input len_t              span_r
);
    localparam int unsigned UP_LIMIT = SETTLE_CYC + 1 + LATENCY;

    int unsigned up_cnt;

    always_ff @(posedge clk) begin
        if (rst || !link_up)
            up_cnt <= 0;
        else if (up_cnt < UP_LIMIT)
            up_cnt <= up_cnt + 1;
    end

    // R9
    link_drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> result == '0);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (result[WORD_W-1] && link_up) |=> (result[WORD_W-1] && $stable(result)));

    // R2
    settle_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(result[WORD_W-1]) |-> (up_cnt >= UP_LIMIT));

    // R5
    bracket_order_chk: assert property (@(posedge clk) disable iff (rst)
        in_srch |-> (seg_w.dm < seg_w.dmax));

    // R5
    quot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        div_fin |-> (div_quo <= NUM_W'({span_r, {FRAC_W{1'b0}}})));
endmodule

bind cle_len_est cle_len_est_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .link_up (link_up),
    .result  (result),
    .in_srch (in_srch),
    .seg_w   (seg_w),
    .div_fin (div_fin),
    .div_quo (div_quo),
    .span_r  (span_r)
);

// File: tb/cle_len_est_bench.sv
module cle_len_est_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 40;
    localparam int LAT        = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        link_up = 1'b0;
    logic        amp_hi = 1'b0;
    logic        metric_valid = 1'b0;
    logic [15:0] metric_in = '0;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    int tl[6];
    int ml[6];
    int mh[6];
    int scnt = 0;
    int lat = 0;
    int pend = 0;
    logic [15:0] exp_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cle_len_est #(.SETTLE_CYC(SETTLE)) u_cle_len_est (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_up(link_up), .amp_hi(amp_hi), .metric_valid(metric_valid),
        .metric_in(metric_in), .result(result)
    );

    function automatic int ref_est(int code, bit hi);
        int m[6];
        for (int i = 0; i < 6; i++) m[i] = hi ? mh[i] : ml[i];
        if (code <= m[0]) return tl[0] * 8;
        for (int i = 0; i < 5; i++)
            if (m[i+1] > m[i] && code >= m[i] && code < m[i+1])
                return tl[i] * 8 + ((code - m[i]) * (tl[i+1] - tl[i]) * 8) / (m[i+1] - m[i]);
        return tl[5] * 8;
    endfunction

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 6; i++) begin tl[i] = 0; ml[i] = 0; mh[i] = 0; end
            scnt = 0; lat = 0; exp_word = '0;
        end else begin
            if (!link_up) begin
                scnt = 0; lat = 0; exp_word = '0;
            end else begin
                if (lat > 0) begin
                    lat = lat - 1;
                    if (lat == 0) exp_word = {1'b1, 4'b0000, pend[10:0]};
                end else if (!exp_word[15] && scnt >= SETTLE && metric_valid) begin
                    pend = ref_est(int'(metric_in[15:4]), amp_hi);
                    lat = LAT;
                end
                if (scnt < SETTLE) scnt = scnt + 1;
            end
            if (wr_en && wr_addr[2:0] < 3'd6) begin
                case (wr_addr[4:3])
                    2'd0: tl[wr_addr[2:0]] = int'(wr_data[7:0]);
                    2'd1: ml[wr_addr[2:0]] = int'(wr_data[11:0]);
                    2'd2: mh[wr_addr[2:0]] = int'(wr_data[11:0]);
                    default: ;
                endcase
            end
        end
    end

    // R8: per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            checks++;
            if (result !== exp_word) begin
                errors++;
                $display("FAIL R8 per-cycle model: got %h expected %h", result, exp_word);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic link_restart();
        link_up = 1'b0;
        cyc(1);
        link_up = 1'b1;
    endtask

    task automatic pulse(logic [15:0] w, bit hi);
        metric_valid = 1'b1; metric_in = w; amp_hi = hi;
        cyc(1);
        metric_valid = 1'b0; metric_in = 16'hFFFF; amp_hi = ~hi;
    endtask

    task automatic estimate(logic [15:0] w, bit hi, int exp_m, string tag);
        link_restart();
        cyc(SETTLE);
        pulse(w, hi);
        cyc(LAT - 1);
        chk({tag, " latency not yet done"}, result, 16'h0000);
        cyc(1);
        chk(tag, result, {1'b1, 4'b0000, 11'(exp_m)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R8 reset state", result, 16'h0000);
        rst = 1'b0;
        cmp_on = 1'b1;
        cyc(1);
        // length table: 0, 200, 400, 600, 800, 1000 m
        wr(5'd0, 16'd0);  wr(5'd1, 16'd25); wr(5'd2, 16'd50);
        wr(5'd3, 16'd75); wr(5'd4, 16'd100); wr(5'd5, 16'd125);
        wr(5'd8,  16'h0050); wr(5'd9,  16'h0070); wr(5'd10, 16'h0090);
        wr(5'd11, 16'h0130); wr(5'd12, 16'h0180); wr(5'd13, 16'h0260);
        wr(5'd16, 16'h0080); wr(5'd17, 16'h00A0); wr(5'd18, 16'h0128);
        wr(5'd19, 16'h0180); wr(5'd20, 16'h0210); wr(5'd21, 16'h0300);

        // R2: strobe before settling is ignored, later one accepted
        link_restart();
        cyc(2);
        pulse(16'h080F, 1'b0);
        cyc(LAT + 2);
        chk("R2 early strobe ignored", result, 16'h0000);
        cyc(15);
        chk("R2 no estimate without strobe", result, 16'h0000);
        pulse(16'h080F, 1'b0);
        cyc(LAT);
        chk("R2 strobe after settling", result, {5'b10000, 11'd300});

        // R5 interpolation and R3 low nibble
        estimate(16'h080F, 1'b0, 300, "R5 low bank mid segment");
        estimate(16'h0800, 1'b0, 300, "R3 low nibble ignored");
        estimate(16'h0A00, 1'b0, 420, "R4 low bank code 0x0A0");
        estimate(16'h0A00, 1'b1, 200, "R4 high bank code 0x0A0");
        estimate(16'h1003, 1'b1, 341, "R5 high bank truncation");
        estimate(int'(ref_est(12'h100, 1'b1)) == 341 ? 16'h1003 : 16'h0000, 1'b1, 341, "R5 reference agrees");

        // R6 clamps and exact points
        estimate(16'h0400, 1'b0, 0,    "R6 below first point");
        estimate(16'h0500, 1'b0, 0,    "R6 equal first point");
        estimate(16'h1300, 1'b0, 600,  "R6 equal interior point");
        estimate(16'h2600, 1'b0, 1000, "R6 equal last point");
        estimate(16'hFFF0, 1'b1, 1000, "R6 above last point");

        // R1 writes to unused addresses leave the table alone
        wr(5'd6, 16'h00FF); wr(5'd14, 16'h0FFF); wr(5'd24, 16'h0001); wr(5'd31, 16'h0FFF);
        estimate(16'h0800, 1'b0, 300, "R1 ignored addresses");
        estimate(16'hFFF0, 1'b0, 1000, "R1 last length intact");

        // R10: one estimate per link-up
        link_restart();
        cyc(SETTLE);
        pulse(16'h0800, 1'b0);
        cyc(3);
        pulse(16'h2000, 1'b1);
        cyc(LAT - 4);
        chk("R10 strobe while busy ignored", result, {5'b10000, 11'd300});
        pulse(16'h3000, 1'b1);
        cyc(LAT + 2);
        chk("R10 strobe after done ignored", result, {5'b10000, 11'd300});

        // R9: link drop clears and aborts
        link_up = 1'b0;
        cyc(1);
        chk("R9 drop clears result", result, 16'h0000);
        link_up = 1'b1;
        cyc(SETTLE);
        pulse(16'h0800, 1'b0);
        cyc(5);
        link_up = 1'b0;
        cyc(1);
        chk("R9 abort clears", result, 16'h0000);
        link_up = 1'b1;
        cyc(LAT + 5);
        chk("R9 aborted estimate not resumed", result, 16'h0000);

        // R7 falling metric segment skipped
        wr(5'd10, 16'h0040);
        estimate(16'h0800, 1'b0, 453, "R7 skip falling segment");
        estimate(16'h0600, 1'b0, 100, "R7 first segment still used");

        // R5 falling length segment
        wr(5'd10, 16'h0090);
        wr(5'd5, 16'd90);
        estimate(16'h2000, 1'b0, 755, "R5 falling length");
        estimate(16'hFFF0, 1'b0, 720, "R6 clamp to rewritten last length");

        cmp_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule